// File: doc/BRIEF.md
# Byte-Lane SRAM Device Logic

This block is the device side of an asynchronous 16-bit static RAM, written as synthesizable logic. A fast internal clock samples the pins. The block turns the chip select, the write strobe, the output enable and one active-low strobe per byte lane into one of four device modes and a low-power flag. It stores written bytes into an internal array. It also drives per-lane output enables for the shared data bus.

Every pin first passes through a two-flop synchronizer, so the decode works on clean, clocked copies of the pins. A write lasts as long as the chip select and the write strobe are both low. While it is open, the block samples the bus data, the address and the lane strobes on every internal clock. It commits to the array when whichever of the two signals rises first closes the window. The array depth is a parameter, so simulation can use a small memory. Its contents survive standby.

Top module: `sram_lane_dev`

## Requirements
- R1: With `chip_sel_n` high, `dev_mode` is 0 (deselect), `low_power` is 1 and `bus_drive` is all zero, whatever the other pins are.
- R2: With `chip_sel_n` low and every bit of `lane_sel_n` high, the block also reports deselect, `low_power` 1 and no drive. A write attempted in this state changes no stored byte.
- R3: A read has `chip_sel_n` low, `wr_strobe_n` high and `out_en_n` low. It reports `dev_mode` 1 and sets `bus_drive[i]` only for lanes whose `lane_sel_n[i]` is low. Lane 0 is `bus_out[7:0]` and lane 1 is `bus_out[15:8]`. A lane that is not driven shows zero on `bus_out`.
- R4: With `chip_sel_n` low, `wr_strobe_n` high, `out_en_n` high and at least one lane strobe low, `dev_mode` is 3 (outputs off), `low_power` is 0 and `bus_drive` is zero.
- R5: With `chip_sel_n` and `wr_strobe_n` both low and a lane strobe low, `dev_mode` is 2 (write) and `low_power` is 0. `bus_drive` stays zero whatever `out_en_n` is.
- R6: A write stores only the lanes whose strobe was low during the write window. The other lanes keep their earlier contents.
- R7: A write commits when either `chip_sel_n` or `wr_strobe_n` rises. For each lane, the value stored is the last bus sample taken while that lane's strobe was low inside the window. The address stored is the last address sampled inside the window.
- R8: When `chip_sel_n` and `wr_strobe_n` rise together, `bus_drive` stays zero on every cycle that follows, and the write still commits.
- R9: Outputs respond to a pin change on the second rising clock edge after the change, and not on the first.
- R10: Stored data survives any length of standby. The row is taken from the low log2(DEPTH) address bits, so addresses that differ only above those bits select the same row.
- R11: While `rst_n` is low, the block reports deselect, `low_power` 1 and no drive. A write window cut by reset commits nothing, and the array keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Device select, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| lane_sel_n | input | LANES (2) | Per-byte-lane strobes, active low, bit 0 is the low byte |
| adr | input | ADDR_W (17) | Word address |
| bus_in | input | DATA_W (16) | Data seen on the bus pins |
| bus_out | output | DATA_W (16) | Read data, zero on lanes not driven |
| bus_drive | output | LANES (2) | Per-lane output drive enable |
| dev_mode | output | 2 | 0 deselect, 1 read, 2 write, 3 outputs off |
| low_power | output | 1 | 1 in standby, 0 when active |

## Verification
A wrong decode shows two sync edges after a pin change. It appears as a mode code or lane enable that disagrees with the pin combination, or as drive asserted during a write. A stale or wrongly cleared lane flag in the write capture does not show at once. It shows only at the next read of that row, as a wrong byte in one lane or as a byte that should not have changed. The bench therefore reads back every row after each style of write ending. A commit that fires on reset, or a commit that is missed when both strobes rise together, shows the same way on the first read of that row.

// File: rtl/sramdev_pkg.sv
package sramdev_pkg;

  typedef enum logic [1:0] {
    MODE_DESEL  = 2'd0,
    MODE_READ   = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_OUTOFF = 2'd3
  } dev_mode_e;

  // Priority: select, then lane strobes, then write strobe, then output enable.
  function automatic dev_mode_e mode_of(input logic sel_n, input logic wr_n,
                                        input logic oe_n, input logic no_lane);
    if (sel_n)        return MODE_DESEL;
    else if (no_lane) return MODE_DESEL;
    else if (!wr_n)   return MODE_WRITE;
    else if (!oe_n)   return MODE_READ;
    else              return MODE_OUTOFF;
  endfunction

  function automatic logic is_standby(input dev_mode_e m);
    return (m == MODE_DESEL);
  endfunction

  function automatic logic write_window(input logic sel_n, input logic wr_n);
    return (!sel_n) && (!wr_n);
  endfunction

endpackage

// File: rtl/sramdev_sync.sv
module sramdev_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sramdev_decode.sv
module sramdev_decode
  import sramdev_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  output dev_mode_e        mode,
  output logic [LANES-1:0] drive,
  output logic             standby,
  output logic             ovl,
  output logic [LANES-1:0] lane_act
);
  always_comb begin
    mode     = mode_of(sel_n, wr_n, oe_n, &lane_n);
    standby  = is_standby(mode);
    ovl      = write_window(sel_n, wr_n);
    lane_act = ~lane_n;
    drive    = (mode == MODE_READ) ? ~lane_n : '0;
  end
endmodule

// File: rtl/sramdev_wrctl.sv
module sramdev_wrctl #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ovl,
  input  logic [LANES-1:0]        lane_act,
  input  logic [ADDR_W-1:0]       adr,
  input  logic [LANES*LANE_W-1:0] data,
  output logic                    commit,
  output logic [ADDR_W-1:0]       cmt_adr,
  output logic [LANES*LANE_W-1:0] cmt_data,
  output logic [LANES-1:0]        cmt_lanes
);
  localparam int DATA_W = LANES * LANE_W;

  logic              ovl_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q  <= 1'b0;
      adr_q  <= '0;
      data_q <= '0;
      hit_q  <= '0;
    end else begin
      ovl_q <= ovl;
      if (ovl) adr_q <= adr;
      for (int l = 0; l < LANES; l++) begin
        if (ovl && lane_act[l]) begin
          hit_q[l]                   <= 1'b1;
          data_q[l*LANE_W +: LANE_W] <= data[l*LANE_W +: LANE_W];
        end else if (!ovl) begin
          hit_q[l] <= 1'b0;
        end
      end
    end
  end

  // Window closed on this cycle: the held samples are the last in-window ones.
  assign commit    = ovl_q & ~ovl;
  assign cmt_adr   = adr_q;
  assign cmt_data  = data_q;
  assign cmt_lanes = hit_q;
endmodule

// File: rtl/sramdev_array.sv
module sramdev_array #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_adr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       rd_adr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign wr_idx = wr_adr[IDX_W-1:0];
  assign rd_idx = rd_adr[IDX_W-1:0];

  generate
    if (IDX_W < ADDR_W) begin : g_fold
      logic unused_hi_bits;
      assign unused_hi_bits = ^{wr_adr[ADDR_W-1:IDX_W], rd_adr[ADDR_W-1:IDX_W]};
    end
  endgenerate

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (wr_en && wr_lanes[g]) mem[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_data[g*LANE_W +: LANE_W] = mem[rd_idx];
    end
  endgenerate
endmodule

// File: rtl/sram_lane_dev.sv
module sram_lane_dev
  import sramdev_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chip_sel_n,
  input  logic                    wr_strobe_n,
  input  logic                    out_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [ADDR_W-1:0]       adr,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES*LANE_W-1:0] bus_out,
  output logic [LANES-1:0]        bus_drive,
  output logic [1:0]              dev_mode,
  output logic                    low_power
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int CTRL_W = 3 + LANES;
  localparam int PAY_W  = ADDR_W + DATA_W;

  // Synchronized pins
  logic [CTRL_W-1:0] ctrl_s;
  logic [PAY_W-1:0]  pay_s;
  logic              sel_s, wr_s, oe_s;
  logic [LANES-1:0]  lane_s;
  logic [ADDR_W-1:0] adr_s;
  logic [DATA_W-1:0] data_s;

  sramdev_sync #(.W(CTRL_W), .STAGES(2), .RST_VAL({CTRL_W{1'b1}})) u_sync_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({chip_sel_n, wr_strobe_n, out_en_n, lane_sel_n}),
    .q     (ctrl_s)
  );

  sramdev_sync #(.W(PAY_W), .STAGES(2), .RST_VAL('0)) u_sync_pay (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({adr, bus_in}),
    .q     (pay_s)
  );

  assign {sel_s, wr_s, oe_s, lane_s} = ctrl_s;
  assign {adr_s, data_s}             = pay_s;

  // Decode: named events for the checker
  dev_mode_e        mode_w;
  logic [LANES-1:0] drive_w;
  logic             stby_w;
  logic             wr_ovl;
  logic [LANES-1:0] lane_act;

  sramdev_decode #(.LANES(LANES)) u_dec (
    .sel_n    (sel_s),
    .wr_n     (wr_s),
    .oe_n     (oe_s),
    .lane_n   (lane_s),
    .mode     (mode_w),
    .drive    (drive_w),
    .standby  (stby_w),
    .ovl      (wr_ovl),
    .lane_act (lane_act)
  );

  // Write capture and commit
  logic              wr_commit;
  logic [ADDR_W-1:0] cmt_adr;
  logic [DATA_W-1:0] cmt_data;
  logic [LANES-1:0]  cmt_lanes;

  sramdev_wrctl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovl       (wr_ovl),
    .lane_act  (lane_act),
    .adr       (adr_s),
    .data      (data_s),
    .commit    (wr_commit),
    .cmt_adr   (cmt_adr),
    .cmt_data  (cmt_data),
    .cmt_lanes (cmt_lanes)
  );

  // Storage
  logic [DATA_W-1:0] rd_word;

  sramdev_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_mem (
    .clk      (clk),
    .wr_en    (wr_commit),
    .wr_adr   (cmt_adr),
    .wr_data  (cmt_data),
    .wr_lanes (cmt_lanes),
    .rd_adr   (adr_s),
    .rd_data  (rd_word)
  );

  // Output lanes
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_out
      assign bus_out[g*LANE_W +: LANE_W] = drive_w[g] ? rd_word[g*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  assign bus_drive = drive_w;
  assign dev_mode  = mode_w;
  assign low_power = stby_w;
endmodule

// File: rtl/sramdev_chk.sv
module sramdev_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       dev_mode,
  input logic [LANES-1:0] bus_drive,
  input logic             low_power,
  input logic             wr_ovl,
  input logic             wr_commit
);
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mode == 2'd0) |-> (bus_drive == '0) && low_power); // R1

  AST_POWER_ONLY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (dev_mode == 2'd0)); // R2

  AST_READ_ONLY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive != '0) |-> (dev_mode == 2'd1)); // R3

  AST_OUTOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mode == 2'd3) |-> (bus_drive == '0) && !low_power); // R4

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mode == 2'd2) |-> (bus_drive == '0) && wr_ovl); // R5

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R7

  AST_COMMIT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !wr_ovl); // R7

  AST_JOINT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && dev_mode == 2'd0) |=> (bus_drive == '0) || (dev_mode == 2'd1)); // R8
endmodule

bind sram_lane_dev sramdev_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_mode  (dev_mode),
  .bus_drive (bus_drive),
  .low_power (low_power),
  .wr_ovl    (wr_ovl),
  .wr_commit (wr_commit)
);

// File: tb/test_sram_lane_dev.sv
module test_sram_lane_dev;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DEPTH  = 256;
  localparam int DATA_W = LANES * LANE_W;

  // Entry: {sel_n, wr_n, oe_n, hi_n, lo_n, mode[1:0], drive[1:0], low_power}
  localparam int NVEC = 11;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b11000_00_00_1,  // R1 deselect
    10'b10000_00_00_1,  // R1 select high beats write
    10'b01011_00_00_1,  // R2 no lane
    10'b00011_00_00_1,  // R2 write with no lane
    10'b01000_01_11_0,  // R3 read both lanes
    10'b01010_01_01_0,  // R3 read low lane
    10'b01001_01_10_0,  // R3 read high lane
    10'b01100_11_00_0,  // R4 outputs off
    10'b01110_11_00_0,  // R4 outputs off, low lane
    10'b00000_10_00_0,  // R5 write, output enable low
    10'b00101_10_00_0   // R5 write, high lane
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              chip_sel_n = 1'b1;
  logic              wr_strobe_n = 1'b1;
  logic              out_en_n = 1'b1;
  logic [LANES-1:0]  lane_sel_n = '1;
  logic [ADDR_W-1:0] adr = '0;
  logic [DATA_W-1:0] bus_in = '0;
  logic [DATA_W-1:0] bus_out;
  logic [LANES-1:0]  bus_drive;
  logic [1:0]        dev_mode;
  logic              low_power;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_dev #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) i_sram_lane_dev (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_sel_n  (chip_sel_n),
    .wr_strobe_n (wr_strobe_n),
    .out_en_n    (out_en_n),
    .lane_sel_n  (lane_sel_n),
    .adr         (adr),
    .bus_in      (bus_in),
    .bus_out     (bus_out),
    .bus_drive   (bus_drive),
    .dev_mode    (dev_mode),
    .low_power   (low_power)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input logic s, input logic w, input logic o, input logic [1:0] ln);
    chip_sel_n = s; wr_strobe_n = w; out_en_n = o; lane_sel_n = ln;
  endtask

  task automatic idle();
    @(negedge clk);
    pins(1'b1, 1'b1, 1'b1, 2'b11);
    settle();
  endtask

  task automatic write_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic [1:0] ln);
    @(negedge clk);
    adr = a; bus_in = d;
    pins(1'b0, 1'b0, 1'b1, ln);
    settle();
    wr_strobe_n = 1'b1;
    settle();
    chip_sel_n = 1'b1;
    settle();
  endtask

  task automatic read_word(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    adr = a;
    pins(1'b0, 1'b1, 1'b0, 2'b00);
    settle();
    d = bus_out;
    pins(1'b1, 1'b1, 1'b1, 2'b11);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;
    logic [4:0] got;

    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dev_mode == 2'd0 && low_power && bus_drive == 2'b00, "R11 reset state",
        {dev_mode, bus_drive, low_power}, 5'b00_00_1);
    rst_n = 1'b1;
    settle();

    // Truth-table walk
    adr = 17'd200; bus_in = 16'h0000;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      pins(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:5]);
      settle();
      got = {dev_mode, bus_drive, low_power};
      chk(got == VEC[i][4:0], $sformatf("R1-table row %0d (R1 R2 R3 R4 R5)", i), got, VEC[i][4:0]);
    end
    idle();

    // R6: lane-selective writes
    write_word(17'd5, 16'hA5C3, 2'b00);
    read_word(17'd5, rd);
    chk(rd == 16'hA5C3, "R6 full word", rd, 16'hA5C3);
    write_word(17'd5, 16'h7E99, 2'b01);
    read_word(17'd5, rd);
    chk(rd == 16'h7EC3, "R6 high lane only", rd, 16'h7EC3);
    write_word(17'd5, 16'h1234, 2'b10);
    read_word(17'd5, rd);
    chk(rd == 16'h7E34, "R6 low lane only", rd, 16'h7E34);

    // R2: write with no lane strobe changes nothing
    write_word(17'd5, 16'hFFFF, 2'b11);
    read_word(17'd5, rd);
    chk(rd == 16'h7E34, "R2 no-lane write ignored", rd, 16'h7E34);

    // R3: single-lane read masks the other lane
    @(negedge clk);
    adr = 17'd5;
    pins(1'b0, 1'b1, 1'b0, 2'b10);
    settle();
    chk(bus_out == 16'h0034 && bus_drive == 2'b01, "R3 low lane read",
        {bus_drive, bus_out}, {2'b01, 16'h0034});
    idle();

    // R7: per-lane last sample, window closed by write strobe
    write_word(17'd9, 16'h0000, 2'b00);
    @(negedge clk);
    adr = 17'd9; bus_in = 16'h1111;
    pins(1'b0, 1'b0, 1'b1, 2'b00);
    settle();
    bus_in = 16'h2222;
    settle();
    lane_sel_n = 2'b01; bus_in = 16'h3333;
    settle();
    wr_strobe_n = 1'b1;
    settle();
    chip_sel_n = 1'b1;
    settle();
    read_word(17'd9, rd);
    chk(rd == 16'h3322, "R7 last sample per lane", rd, 16'h3322);

    // R7: window closed by select while write strobe stays low
    @(negedge clk);
    adr = 17'd10; bus_in = 16'hCAFE;
    pins(1'b0, 1'b0, 1'b1, 2'b00);
    settle();
    chip_sel_n = 1'b1;
    settle();
    wr_strobe_n = 1'b1;
    settle();
    read_word(17'd10, rd);
    chk(rd == 16'hCAFE, "R7 ended by select", rd, 16'hCAFE);

    // R8: both rise together with output enable low
    @(negedge clk);
    adr = 17'd11; bus_in = 16'h5AA5;
    pins(1'b0, 1'b0, 1'b0, 2'b00);
    settle();
    chk(bus_drive == 2'b00 && dev_mode == 2'd2, "R5 write ignores output enable",
        {dev_mode, bus_drive}, {2'd2, 2'b00});
    chip_sel_n = 1'b1; wr_strobe_n = 1'b1;
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (bus_drive != 2'b00) quiet = 1'b0;
      end
      chk(quiet, "R8 joint rise stays undriven", {31'd0, quiet}, 32'd1);
    end
    read_word(17'd11, rd);
    chk(rd == 16'h5AA5, "R8 joint rise commits", rd, 16'h5AA5);

    // R9: two-edge latency
    @(negedge clk);
    adr = 17'd11;
    pins(1'b0, 1'b1, 1'b0, 2'b00);
    @(posedge clk); @(negedge clk);
    chk(dev_mode == 2'd0, "R9 no change after one edge", dev_mode, 2'd0);
    @(posedge clk); @(negedge clk);
    chk(dev_mode == 2'd1, "R9 change after two edges", dev_mode, 2'd1);
    idle();

    // R10: retention across standby and address aliasing
    repeat (40) @(posedge clk);
    read_word(17'd5, rd);
    chk(rd == 16'h7E34, "R10 kept across standby", rd, 16'h7E34);
    write_word(17'd5 + DEPTH, 16'hBEEF, 2'b00);
    read_word(17'd5, rd);
    chk(rd == 16'hBEEF, "R10 alias above depth", rd, 16'hBEEF);

    // R11: reset inside a write window commits nothing, array kept
    @(negedge clk);
    adr = 17'd9; bus_in = 16'hDEAD;
    pins(1'b0, 1'b0, 1'b1, 2'b00);
    settle();
    rst_n = 1'b0;
    @(negedge clk);
    pins(1'b1, 1'b1, 1'b1, 2'b11);
    chk(dev_mode == 2'd0 && low_power && bus_drive == 2'b00, "R11 reset mid-write state",
        {dev_mode, bus_drive, low_power}, 5'b00_00_1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    read_word(17'd9, rd);
    chk(rd == 16'h3322, "R11 no commit on reset", rd, 16'h3322);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule